// File: doc/BRIEF.md
# Serial LCD Frame Refresh Sequencer

This block keeps a 128x64 monochrome graphic LCD refreshed over a write-only serial link. It runs without pause. Each frame starts with a controller setup burst of 14 command bytes. The panel is then walked one 8-row page at a time. Each page gets a short command burst that selects the page and resets the column to zero, followed by a burst of pixel bytes. The pixel bytes are fetched from an external frame-buffer read port. After the last page, the sequence starts again with the setup burst.

The link has four outputs: an active-low chip select, a serial clock that idles low, serial data shifted most significant bit first, and a select line that is 0 for command bytes and 1 for pixel bytes. The serial clock is the system clock divided by `2*HALF_DIV`. The default of 50 gives 2 MHz from a 200 MHz clock, and `HALF_DIV` must be at least 2. A display enable input changes two bytes of the setup burst: the contrast value and the final on/off command. This switches the panel dark or back on from the next frame. The frame buffer holds `ROW_WIDTH` bytes per page. `ACTIVE_WIDTH` of them are sent, and `NUM_PAGES` (at most 16) pages make a frame.

Top module: `lcd_refresh_seq`

## Requirements
- R1: `rst` is a synchronous, active-high reset. While it is held, and in the first cycle after it is released, `lcd_cs_n`=1, `lcd_sclk`=0, `lcd_dc`=0, `fb_rd_en`=0 and `frame_done`=0. The first burst after reset is the setup burst.
- R2: The setup burst sends these 14 bytes in order, with `lcd_dc`=0: A2 2F A4 A6 40 81 3F A0 27 C8 F8 00 E3 AF (hex).
- R3: `disp_on` is sampled in the last cycle before `lcd_cs_n` falls for a setup burst. If it is 0 there, setup byte 6 is 00 and byte 13 is AE. If it is 1, they are 3F and AF. Changes at any other time do not affect the frame in progress.
- R4: Each page command burst sends three bytes with `lcd_dc`=0: B0 OR page, then 10, then 00.
- R5: Each pixel burst sends `ACTIVE_WIDTH` bytes with `lcd_dc`=1. Byte i is read from address page*`ROW_WIDTH`+i.
- R6: The burst order is: setup, then for page 0 up to `NUM_PAGES`-1 a page command followed by its pixel burst, then setup again.
- R7: Each bit lasts `2*HALF_DIV` clocks. `lcd_sclk` is 0 for the first `HALF_DIV` clocks and 1 for the second, and `lcd_sdo` holds the bit throughout. Bits go MSB first, and the bytes of a burst follow one another without a break. `lcd_sclk` is 0 whenever `lcd_cs_n` is 1.
- R8: Before every burst, including the first after reset, `lcd_cs_n` is 1 for exactly `2*HALF_DIV` cycles. `lcd_dc` takes the value of the coming burst in the second of those cycles and changes at no other time.
- R9: `fb_rd_en` is high for single cycles only. For pixel byte 0 it is high in the second gap cycle. For byte i+1 it is high in the second cycle of byte i. `fb_rd_data` is used in the cycle after the strobe. There are no other strobes.
- R10: `frame_done` is high for exactly one cycle. That cycle is the first cycle `lcd_cs_n` is 1 after the last page's pixel burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_on | input | 1 | 1 = panel on, 0 = panel dark (applied at next setup burst) |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_sclk | output | 1 | Serial clock, idles low |
| lcd_sdo | output | 1 | Serial data, MSB first |
| lcd_dc | output | 1 | 0 = command byte, 1 = pixel byte |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_addr | output | ADDR_W | Frame-buffer read address |
| fb_rd_data | input | 8 | Frame-buffer data, valid the cycle after the strobe |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
A reference model in the bench predicts every output pin on every clock, across several frames. The row stride is wider than the active width. If the design stepped addresses by the active width, pixels from the wrong row would appear in page 1. `disp_on` is switched in the middle of frames. A design that sampled it directly instead of latching it at the setup burst would show 00/AE or 3F/AF in the wrong frame. The select line is compared in the very first gap cycle. A design that changed it at the same edge that raises chip select, or one that used the read data a cycle early, would miscompare there. A second reset applied in the middle of a burst checks that the sequence restarts with a clean gap and a setup burst.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        BK_SETUP = 2'd0,
        BK_PAGE  = 2'd1,
        BK_PIXEL = 2'd2
    } burst_e;

    typedef enum logic {
        PH_GAP   = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    localparam int SETUP_LEN    = 14;
    localparam int PAGE_CMD_LEN = 3;

    // Setup command stream; bytes 6 and 13 depend on the display enable
    function automatic logic [7:0] setup_byte(input int unsigned idx, input logic on);
        logic [7:0] b;
        case (idx)
            0:       b = 8'hA2;
            1:       b = 8'h2F;
            2:       b = 8'hA4;
            3:       b = 8'hA6;
            4:       b = 8'h40;
            5:       b = 8'h81;
            6:       b = on ? 8'h3F : 8'h00;
            7:       b = 8'hA0;
            8:       b = 8'h27;
            9:       b = 8'hC8;
            10:      b = 8'hF8;
            11:      b = 8'h00;
            12:      b = 8'hE3;
            13:      b = on ? 8'hAF : 8'hAE;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    // Page select followed by column address zero (high then low nibble)
    function automatic logic [7:0] page_cmd_byte(input int unsigned idx, input logic [3:0] page);
        logic [7:0] b;
        case (idx)
            0:       b = {4'hB, page};
            1:       b = 8'h10;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
    import lcd_seq_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PAGE_W = 3
) (
    input  burst_e              kind,
    input  logic [IDX_W-1:0]    idx,
    input  logic [PAGE_W-1:0]   page,
    input  logic                disp_on,
    output logic [7:0]          cmd_byte
);

    logic [3:0] page4;

    generate
        if (PAGE_W >= 4) begin : g_page_trim
            assign page4 = page[3:0];
        end else begin : g_page_pad
            assign page4 = {{(4 - PAGE_W){1'b0}}, page};
        end
    endgenerate

    always_comb begin
        if (kind == BK_SETUP) begin
            cmd_byte = setup_byte(int'(idx), disp_on);
        end else begin
            cmd_byte = page_cmd_byte(int'(idx), page4);
        end
    end

endmodule

// File: rtl/lcd_fb_fetch.sv
module lcd_fb_fetch (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_issued,
    input  logic [7:0] rd_data,
    output logic [7:0] fetched
);

    typedef struct packed {
        logic       pend;
        logic [7:0] data;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.pend = rd_issued;
        if (f_q.pend) begin
            f_d.data = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fetched = f_q.data;

endmodule

// File: rtl/lcd_refresh_seq.sv
module lcd_refresh_seq
    import lcd_seq_pkg::*;
#(
    parameter int HALF_DIV     = 50,
    parameter int NUM_PAGES    = 8,
    parameter int ACTIVE_WIDTH = 128,
    parameter int ROW_WIDTH    = 128,
    parameter int ADDR_W       = $clog2(NUM_PAGES * ROW_WIDTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_on,
    output logic              lcd_cs_n,
    output logic              lcd_sclk,
    output logic              lcd_sdo,
    output logic              lcd_dc,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_addr,
    input  logic [7:0]        fb_rd_data,
    output logic              frame_done
);

    localparam int GAP_LAST  = 2 * HALF_DIV - 1;
    localparam int HALF_LAST = HALF_DIV - 1;
    localparam int CNT_W     = $clog2(2 * HALF_DIV);
    localparam int MAX_LEN   = (ACTIVE_WIDTH > SETUP_LEN) ? ACTIVE_WIDTH : SETUP_LEN;
    localparam int IDX_W     = $clog2(MAX_LEN);
    localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int PAGE_LAST = NUM_PAGES - 1;

    typedef struct packed {
        phase_e              phase;
        burst_e              kind;
        logic [PAGE_W-1:0]   page;
        logic [CNT_W-1:0]    cnt;
        logic [2:0]          bitn;
        logic [IDX_W-1:0]    idx;
        logic [7:0]          shreg;
        logic                cs_n;
        logic                sclk;
        logic                dc;
        logic                rd_en;
        logic [ADDR_W-1:0]   addr;
        logic                on;
        logic                done;
    } seq_t;

    seq_t st_d, st_q;

    logic [IDX_W-1:0] rom_idx;
    logic [7:0]       rom_byte;
    logic [7:0]       fetched;
    logic [IDX_W-1:0] idx_last;

    // Byte index into the command stream for the next byte to be loaded
    always_comb begin
        if (st_q.phase == PH_GAP) begin
            rom_idx = '0;
        end else begin
            rom_idx = st_q.idx + IDX_W'(1);
        end
    end

    always_comb begin
        case (st_q.kind)
            BK_SETUP: idx_last = IDX_W'(SETUP_LEN - 1);
            BK_PAGE:  idx_last = IDX_W'(PAGE_CMD_LEN - 1);
            default:  idx_last = IDX_W'(ACTIVE_WIDTH - 1);
        endcase
    end

    lcd_cmd_rom #(
        .IDX_W  (IDX_W),
        .PAGE_W (PAGE_W)
    ) i_cmd_rom (
        .kind     (st_q.kind),
        .idx      (rom_idx),
        .page     (st_q.page),
        .disp_on  (st_q.on),
        .cmd_byte (rom_byte)
    );

    lcd_fb_fetch i_fb_fetch (
        .clk       (clk),
        .rst       (rst),
        .rd_issued (st_q.rd_en),
        .rd_data   (fb_rd_data),
        .fetched   (fetched)
    );

    function automatic logic [ADDR_W-1:0] pix_addr(input logic [PAGE_W-1:0] pg,
                                                   input int unsigned col);
        return ADDR_W'(int'(pg) * ROW_WIDTH + int'(col));
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.rd_en = 1'b0;
        st_d.done  = 1'b0;

        if (st_q.phase == PH_GAP) begin
            // Select line settles one cycle after chip select has gone high
            st_d.dc = (st_q.kind == BK_PIXEL);
            if (st_q.kind == BK_PIXEL && st_q.cnt == '0) begin
                st_d.rd_en = 1'b1;
                st_d.addr  = pix_addr(st_q.page, 0);
            end
            if (st_q.cnt == CNT_W'(GAP_LAST)) begin
                st_d.phase = PH_SHIFT;
                st_d.cs_n  = 1'b0;
                st_d.sclk  = 1'b0;
                st_d.cnt   = '0;
                st_d.bitn  = '0;
                st_d.idx   = '0;
                st_d.shreg = (st_q.kind == BK_PIXEL) ? fetched : rom_byte;
                if (st_q.kind == BK_SETUP) begin
                    st_d.on = disp_on;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            // Prefetch the following pixel byte at the start of each byte
            if (st_q.kind == BK_PIXEL && !st_q.sclk && st_q.cnt == '0 &&
                st_q.bitn == '0 && st_q.idx != idx_last) begin
                st_d.rd_en = 1'b1;
                st_d.addr  = pix_addr(st_q.page, int'(st_q.idx) + 1);
            end
            if (st_q.cnt == CNT_W'(HALF_LAST)) begin
                st_d.cnt = '0;
                if (!st_q.sclk) begin
                    st_d.sclk = 1'b1;
                end else begin
                    st_d.sclk = 1'b0;
                    if (st_q.bitn != 3'd7) begin
                        st_d.bitn  = st_q.bitn + 3'd1;
                        st_d.shreg = {st_q.shreg[6:0], 1'b0};
                    end else if (st_q.idx != idx_last) begin
                        st_d.bitn  = '0;
                        st_d.idx   = st_q.idx + IDX_W'(1);
                        st_d.shreg = (st_q.kind == BK_PIXEL) ? fetched : rom_byte;
                    end else begin
                        st_d.phase = PH_GAP;
                        st_d.cs_n  = 1'b1;
                        case (st_q.kind)
                            BK_SETUP: begin
                                st_d.kind = BK_PAGE;
                                st_d.page = '0;
                            end
                            BK_PAGE: begin
                                st_d.kind = BK_PIXEL;
                            end
                            default: begin
                                if (st_q.page == PAGE_W'(PAGE_LAST)) begin
                                    st_d.kind = BK_SETUP;
                                    st_d.page = '0;
                                    st_d.done = 1'b1;
                                end else begin
                                    st_d.kind = BK_PAGE;
                                    st_d.page = st_q.page + PAGE_W'(1);
                                end
                            end
                        endcase
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.phase <= PH_GAP;
            st_q.kind  <= BK_SETUP;
            st_q.cs_n  <= 1'b1;
            st_q.on    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lcd_cs_n   = st_q.cs_n;
    assign lcd_sclk   = st_q.sclk;
    assign lcd_sdo    = st_q.shreg[7];
    assign lcd_dc     = st_q.dc;
    assign fb_rd_en   = st_q.rd_en;
    assign fb_addr    = st_q.addr;
    assign frame_done = st_q.done;

endmodule

// File: rtl/lcd_refresh_seq_chk.sv
module lcd_refresh_seq_chk #(
    parameter int HALF_DIV = 50
) (
    input logic clk,
    input logic rst,
    input logic lcd_cs_n,
    input logic lcd_sclk,
    input logic lcd_dc,
    input logic fb_rd_en,
    input logic frame_done
);

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (!lcd_cs_n) begin
            hi_run <= '0;
        end else if (hi_run != 16'hFFFF) begin
            hi_run <= hi_run + 16'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (lcd_cs_n && !lcd_sclk && !lcd_dc && !fb_rd_en && !frame_done));

    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
        lcd_cs_n |-> !lcd_sclk);

    p_cs_fall_low_clk_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_cs_n) |-> !lcd_sclk);

    p_dc_in_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (lcd_dc != $past(lcd_dc)) |-> (lcd_cs_n && $past(lcd_cs_n)));

    p_gap_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_cs_n) |-> (hi_run == 16'(2 * HALF_DIV)));

    p_rd_single_r9: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |=> !fb_rd_en);

    p_rd_data_phase_r9: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |-> lcd_dc);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_done_at_cs_rise_r10: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (lcd_cs_n && !$past(lcd_cs_n)));

endmodule

bind lcd_refresh_seq lcd_refresh_seq_chk #(.HALF_DIV(HALF_DIV)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .lcd_cs_n   (lcd_cs_n),
    .lcd_sclk   (lcd_sclk),
    .lcd_dc     (lcd_dc),
    .fb_rd_en   (fb_rd_en),
    .frame_done (frame_done)
);

// File: tb/test_lcd_refresh_seq.sv
`timescale 1ns/1ps
module test_lcd_refresh_seq;

    localparam int HD = 2;
    localparam int NP = 2;
    localparam int AW = 6;
    localparam int RW = 8;
    localparam int AD = $clog2(NP * RW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          disp_on = 1'b1;
    logic          lcd_cs_n, lcd_sclk, lcd_sdo, lcd_dc, fb_rd_en, frame_done;
    logic [AD-1:0] fb_addr;
    logic [7:0]    fb_rd_data = 8'h00;
    logic [7:0]    fb_mem [NP*RW];

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    bit prev_dc, prev_last, cur_on;

    always #2.5 clk = ~clk;

    lcd_refresh_seq #(
        .HALF_DIV(HD), .NUM_PAGES(NP), .ACTIVE_WIDTH(AW), .ROW_WIDTH(RW)
    ) i_lcd_refresh_seq (
        .clk(clk), .rst(rst), .disp_on(disp_on),
        .lcd_cs_n(lcd_cs_n), .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo), .lcd_dc(lcd_dc),
        .fb_rd_en(fb_rd_en), .fb_addr(fb_addr), .fb_rd_data(fb_rd_data),
        .frame_done(frame_done)
    );

    always @(posedge clk) if (fb_rd_en) fb_rd_data <= fb_mem[fb_addr];

    function automatic logic [7:0] setup_val(int i, bit on);
        logic [7:0] tab [14] = '{8'hA2, 8'h2F, 8'hA4, 8'hA6, 8'h40, 8'h81, 8'h3F,
                                 8'hA0, 8'h27, 8'hC8, 8'hF8, 8'h00, 8'hE3, 8'hAF};
        if (i == 6)  return on ? 8'h3F : 8'h00;
        if (i == 13) return on ? 8'hAF : 8'hAE;
        return tab[i];
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(bit e_cs, bit e_sclk, bit e_dc, bit sdo_ok, bit e_sdo, string sdo_tag,
                       bit e_rd, int e_addr, bit e_fd);
        @(negedge clk);
        chk("R8", "lcd_cs_n", lcd_cs_n, e_cs);
        chk("R7", "lcd_sclk", lcd_sclk, e_sclk);
        chk("R8", "lcd_dc", lcd_dc, e_dc);
        chk("R9", "fb_rd_en", fb_rd_en, e_rd);
        if (e_rd) chk("R5", "fb_addr", int'(fb_addr), e_addr);
        chk("R10", "frame_done", frame_done, e_fd);
        if (sdo_ok) chk(sdo_tag, "lcd_sdo", lcd_sdo, e_sdo);
    endtask

    // kind: 0 setup, 1 page command, 2 pixel data
    task automatic do_burst(int kind, int page);
        bit new_dc = (kind == 2);
        int nbytes = (kind == 0) ? 14 : (kind == 1) ? 3 : AW;
        int base = page * RW;
        for (int g = 0; g < 2*HD; g++) begin
            cyc(1'b1, 1'b0, (g == 0) ? prev_dc : new_dc, 1'b0, 1'b0, "R8",
                (kind == 2 && g == 1), base, (g == 0) && prev_last);
            if (kind == 0 && g == 2*HD-1) cur_on = disp_on;
        end
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] b;
            string tg;
            if (kind == 0) begin
                b = setup_val(i, cur_on);
                tg = (i == 6 || i == 13) ? "R3" : "R2";
            end else if (kind == 1) begin
                b = (i == 0) ? (8'hB0 | 8'(page)) : (i == 1) ? 8'h10 : 8'h00;
                tg = (i == 0) ? "R6" : "R4";
            end else begin
                b = fb_mem[base + i];
                tg = "R5";
            end
            for (int k = 7; k >= 0; k--) begin
                for (int t = 0; t < 2*HD; t++) begin
                    cyc(1'b0, (t >= HD), new_dc, 1'b1, b[k], tg,
                        (kind == 2 && k == 7 && t == 1 && i < AW-1), base + i + 1, 1'b0);
                end
            end
        end
        prev_dc = new_dc;
        prev_last = (kind == 2 && page == NP-1);
    endtask

    task automatic run_frames(int n);
        prev_dc = 1'b0;
        prev_last = 1'b0;
        for (int f = 0; f < n; f++) begin
            do_burst(0, 0);
            for (int p = 0; p < NP; p++) begin
                do_burst(1, p);
                do_burst(2, p);
            end
        end
    endtask

    task automatic reset_check(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            chk("R1", "lcd_cs_n", lcd_cs_n, 1);
            chk("R1", "lcd_sclk", lcd_sclk, 0);
            chk("R1", "lcd_dc", lcd_dc, 0);
            chk("R1", "fb_rd_en", fb_rd_en, 0);
            chk("R1", "frame_done", frame_done, 0);
        end
    endtask

    // Display enable schedule: toggles land inside frames, away from and at setup sampling
    initial begin
        repeat (500) @(posedge clk);
        #1 disp_on = 1'b0;
        repeat (1000) @(posedge clk);
        #1 disp_on = 1'b1;
        repeat (800) @(posedge clk);
        #1 disp_on = 1'b0;
        repeat (100) @(posedge clk);
        #1 disp_on = 1'b1;
        repeat (100) @(posedge clk);
        #1 disp_on = 1'b0;
    end

    initial begin
        for (int a = 0; a < NP*RW; a++) fb_mem[a] = 8'((a * 29 + 7) ^ (a << 5));
        repeat (3) @(posedge clk);
        reset_check(2);
        @(posedge clk);
        #1 rst = 1'b0;
        run_frames(4);
        repeat (300) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        reset_check(3);
        @(posedge clk);
        #1 rst = 1'b0;
        run_frames(1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule